// File: doc/BRIEF.md
# Masked Control Register File

This block keeps the sixteen 32-bit control registers of a small processor core. Two build parameters shape it. One says whether interrupts arrive from an external vectored controller or from the core's own line-per-source scheme. The other says whether a memory management unit is fitted. From these two settings each register gets a mask of bits that software may change and a mask of bits that only hardware owns. A bit in neither mask is a reserved field and always holds zero. A register with both masks empty is absent: it has no storage and always reads zero.

Software writes through a single write port. The port takes new data only in the writable bits and keeps the stored value in the read-only bits. Reads are combinational. Reset clears every register except the status register, which comes out of reset with its register-set interrupt enable bit set. On the first clock edge after reset is released, the identifier register captures the `cpu_index` input. The write and read ports are plain strobed register ports with no back-pressure: a write is accepted on every edge where `wr_en` is high, and a read is always valid.

Top module: `ctl_reg_bank`

## Requirements
- R1: On a write, the addressed register becomes (wr_data AND writable mask) OR (old value AND read-only mask). Bits in neither mask read 0. Other registers and idle cycles leave the stored values unchanged.
- R2: Registers with both masks zero read 0 and ignore writes. Indices 6, 11, 13, 14 and 15 are always in this group.
- R3: Status (index 0) bit 0, the previous-interrupt-enable bit, is always writable. Index 1 (exception-saved status), index 2 (break-saved status) and index 12 (bad address) are fully writable. Index 5 (identifier) and index 7 (exception cause) are fully read-only.
- R4: With EXT_IRQ_CTRL=1, these status fields are writable: bit 23 (register-set interrupt enable), bits 21:16 (previous register set), bits 9:4 (interrupt level) and bit 3 (interrupt handler mode). Bit 22 (non-maskable active) and bits 15:10 (current register set) are read-only. Index 3 (interrupt enable) and index 4 (interrupt pending) are then absent.
- R5: With EXT_IRQ_CTRL=0, status bit 23 is read-only, index 3 is fully writable and index 4 is fully read-only.
- R6: With HAS_MMU=1, status bit 1 (user mode) and bit 2 (exception handler mode) are writable. In index 8, bits 31:2 are writable. In index 10, bits 5:0 are read-only, and bits 19:6, 20, 21 and 27:24 are writable. Index 9 is fully writable. With HAS_MMU=0, indices 8, 9 and 10 are absent and status bits 1 and 2 read 0.
- R7: During reset, every register reads 0 except status, which reads 0x0080_0000.
- R8: At the first rising edge with rst_n high, index 5 loads cpu_index. This load takes priority over a write to index 5 on the same edge.
- R9: rd_data follows rd_addr combinationally with no clock edge in between. A write is visible on the read port after the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_index | input | 32 | Identifier loaded into index 5 after reset |
| wr_en | input | 1 | Write strobe, accepted on every rising edge where it is high |
| wr_addr | input | 4 | Register index to write |
| wr_data | input | 32 | Write data before masking |
| rd_addr | input | 4 | Register index to read |
| rd_data | output | 32 | Read data, combinational |

## Verification
Two functions can hit the same edge: the identifier capture after reset release and a software write aimed at that same identifier register. The bench releases reset and holds an all-ones write to index 5 across the first edge. It then expects cpu_index on the read port, not the write data. A second instance built with the other pair of parameter values takes the same stimulus, so each mask rule is judged in both configurations from the same write.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;

  localparam int CR_DW    = 32;
  localparam int CR_AW    = 4;
  localparam int CR_COUNT = 1 << CR_AW;

  // register indices (software decodes these)
  localparam int IX_STATUS  = 0;
  localparam int IX_ESAVE   = 1;
  localparam int IX_BSAVE   = 2;
  localparam int IX_IRQ_EN  = 3;
  localparam int IX_IRQ_PND = 4;
  localparam int IX_IDENT   = 5;
  localparam int IX_CAUSE   = 7;
  localparam int IX_PTE     = 8;
  localparam int IX_TLBDATA = 9;
  localparam int IX_TLBCTL  = 10;
  localparam int IX_FAULTVA = 12;

  // status fields
  localparam logic [CR_DW-1:0] ST_PIE  = 32'h0000_0001;
  localparam logic [CR_DW-1:0] ST_USR  = 32'h0000_0002;
  localparam logic [CR_DW-1:0] ST_EXH  = 32'h0000_0004;
  localparam logic [CR_DW-1:0] ST_IHM  = 32'h0000_0008;
  localparam logic [CR_DW-1:0] ST_LVL  = 32'h0000_03F0;
  localparam logic [CR_DW-1:0] ST_CUR  = 32'h0000_FC00;
  localparam logic [CR_DW-1:0] ST_PRV  = 32'h003F_0000;
  localparam logic [CR_DW-1:0] ST_NMA  = 32'h0040_0000;
  localparam logic [CR_DW-1:0] ST_RSEN = 32'h0080_0000;

  // page table entry address fields
  localparam logic [CR_DW-1:0] PT_PAGE = 32'h003F_FFFC;
  localparam logic [CR_DW-1:0] PT_BASE = 32'hFFC0_0000;

  // translation control fields
  localparam logic [CR_DW-1:0] TC_DIRTY = 32'h0000_0001;
  localparam logic [CR_DW-1:0] TC_PERM  = 32'h0000_000E;
  localparam logic [CR_DW-1:0] TC_BAD   = 32'h0000_0010;
  localparam logic [CR_DW-1:0] TC_DBL   = 32'h0000_0020;
  localparam logic [CR_DW-1:0] TC_ASID  = 32'h000F_FFC0;
  localparam logic [CR_DW-1:0] TC_WEN   = 32'h0010_0000;
  localparam logic [CR_DW-1:0] TC_REN   = 32'h0020_0000;
  localparam logic [CR_DW-1:0] TC_SET   = 32'h0F00_0000;

  localparam logic [CR_DW-1:0] ALL_ONES = '1;

  function automatic logic [CR_DW-1:0] cr_wr_mask(int idx, bit ext_irq, bit mmu);
    logic [CR_DW-1:0] m;
    m = '0;
    case (idx)
      IX_STATUS: begin
        m = ST_PIE;
        if (ext_irq) m = m | ST_RSEN | ST_PRV | ST_LVL | ST_IHM;
        if (mmu)     m = m | ST_USR | ST_EXH;
      end
      IX_ESAVE, IX_BSAVE, IX_FAULTVA: m = ALL_ONES;
      IX_IRQ_EN:  if (!ext_irq) m = ALL_ONES;
      IX_PTE:     if (mmu) m = PT_PAGE | PT_BASE;
      IX_TLBCTL:  if (mmu) m = TC_ASID | TC_WEN | TC_REN | TC_SET;
      IX_TLBDATA: if (mmu) m = ALL_ONES;
      default:    m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [CR_DW-1:0] cr_ro_mask(int idx, bit ext_irq, bit mmu);
    logic [CR_DW-1:0] m;
    m = '0;
    case (idx)
      IX_STATUS:  m = ext_irq ? (ST_NMA | ST_CUR) : ST_RSEN;
      IX_IDENT, IX_CAUSE: m = ALL_ONES;
      IX_IRQ_PND: if (!ext_irq) m = ALL_ONES;
      IX_TLBCTL:  if (mmu) m = TC_DIRTY | TC_PERM | TC_BAD | TC_DBL;
      default:    m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [CR_DW-1:0] cr_reset_val(int idx);
    return (idx == IX_STATUS) ? ST_RSEN : '0;
  endfunction

endpackage

// File: rtl/cr_wr_decode.sv
module cr_wr_decode #(
  parameter int AW = 4,
  localparam int N = 1 << AW
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output logic [N-1:0]  sel
);
  for (genvar i = 0; i < N; i++) begin : g_sel
    assign sel[i] = wr_en && (wr_addr == AW'(i));
  end
endmodule

// File: rtl/cr_cell.sv
module cr_cell #(
  parameter int              DW    = 32,
  parameter logic [DW-1:0]   WMASK = '0,
  parameter logic [DW-1:0]   RMASK = '0,
  parameter logic [DW-1:0]   RSTV  = '0,
  localparam bit             ABSENT = (WMASK == '0) && (RMASK == '0)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          load_id,
  input  logic [DW-1:0] id_value,
  output logic [DW-1:0] q
);
  if (ABSENT) begin : g_absent
    logic unused_inputs;
    assign unused_inputs = ^{clk, rst_n, we, wdata, load_id, id_value};
    assign q = '0;
  end else begin : g_store
    logic [DW-1:0] q_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_r <= RSTV;
      else if (load_id) q_r <= id_value;
      else if (we)      q_r <= (wdata & WMASK) | (q_r & RMASK);
    end

    assign q = q_r;

    AST_RO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !load_id) |=> ((q_r & RMASK) == ($past(q_r) & RMASK))); // R1
    AST_WR_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !load_id) |=> ((q_r & WMASK) == ($past(wdata) & WMASK))); // R1
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!we && !load_id) |=> $stable(q_r)); // R1
  end
endmodule

// File: rtl/cr_read_mux.sv
module cr_read_mux #(
  parameter int          DW  = 32,
  parameter int          AW  = 4,
  localparam int         N   = 1 << AW,
  parameter logic [N-1:0] RSV = '0
) (
  input  logic [N-1:0][DW-1:0] regs_i,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_data
);
  always_comb begin
    if (RSV[rd_addr]) rd_data = '0;
    else              rd_data = regs_i[rd_addr];
  end
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_reg_pkg::*;
#(
  parameter bit EXT_IRQ_CTRL = 1'b0,
  parameter bit HAS_MMU      = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CR_DW-1:0] cpu_index,
  input  logic             wr_en,
  input  logic [CR_AW-1:0] wr_addr,
  input  logic [CR_DW-1:0] wr_data,
  input  logic [CR_AW-1:0] rd_addr,
  output logic [CR_DW-1:0] rd_data
);
  logic [CR_COUNT-1:0]            sel;
  logic [CR_COUNT-1:0][CR_DW-1:0] regs_q;
  logic                           id_pending;

  function automatic logic [CR_COUNT-1:0] absent_vec();
    logic [CR_COUNT-1:0] v;
    for (int k = 0; k < CR_COUNT; k++)
      v[k] = (cr_wr_mask(k, EXT_IRQ_CTRL, HAS_MMU) == '0) &&
             (cr_ro_mask(k, EXT_IRQ_CTRL, HAS_MMU) == '0);
    return v;
  endfunction

  localparam logic [CR_COUNT-1:0] ABSENT = absent_vec();

  // identifier capture on the first edge out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) id_pending <= 1'b1;
    else        id_pending <= 1'b0;
  end

  cr_wr_decode #(.AW(CR_AW)) u_dec (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .sel    (sel)
  );

  for (genvar i = 0; i < CR_COUNT; i++) begin : g_reg
    localparam bit IS_ID = (i == IX_IDENT);
    cr_cell #(
      .DW   (CR_DW),
      .WMASK(cr_wr_mask(i, EXT_IRQ_CTRL, HAS_MMU)),
      .RMASK(cr_ro_mask(i, EXT_IRQ_CTRL, HAS_MMU)),
      .RSTV (cr_reset_val(i))
    ) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (sel[i]),
      .wdata   (wr_data),
      .load_id (IS_ID && id_pending),
      .id_value(IS_ID ? cpu_index : '0),
      .q       (regs_q[i])
    );
  end

  cr_read_mux #(.DW(CR_DW), .AW(CR_AW), .RSV(ABSENT)) u_rd (
    .regs_i (regs_q),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  AST_ABSENT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ABSENT[rd_addr] |-> (rd_data == '0)); // R2
  AST_ID_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    id_pending |=> (regs_q[IX_IDENT] == $past(cpu_index))); // R8
  AST_READ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !ABSENT[rd_addr] |-> (rd_data == regs_q[rd_addr])); // R9

  if (!EXT_IRQ_CTRL) begin : g_rsen_fixed
    AST_RSEN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      regs_q[IX_STATUS][23] == 1'b1); // R5
  end
endmodule

// File: tb/test_ctl_reg_bank.sv
module test_ctl_reg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_main, rd_alt;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [31:0] ID_MAIN = 32'h0000_0007;
  localparam logic [31:0] ID_ALT  = 32'h0000_0012;

  always #10 clk = ~clk;  // 50 MHz

  // main: line-per-source interrupts, MMU fitted
  ctl_reg_bank #(.EXT_IRQ_CTRL(1'b0), .HAS_MMU(1'b1)) i_ctl_reg_bank (
    .clk(clk), .rst_n(rst_n), .cpu_index(ID_MAIN),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_main)
  );

  // alternate: external controller, no MMU
  ctl_reg_bank #(.EXT_IRQ_CTRL(1'b1), .HAS_MMU(1'b0)) i_ctl_reg_bank_alt (
    .clk(clk), .rst_n(rst_n), .cpu_index(ID_ALT),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_alt)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd2(logic [3:0] a, string req, logic [31:0] em, logic [31:0] ea);
    rd_addr = a;
    #1;
    check({req, " main"}, rd_main, em);
    check({req, " alt"},  rd_alt,  ea);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    rd2(4'd0, "R7 status", 32'h0080_0000, 32'h0080_0000);
    rd2(4'd1, "R7 esave", 32'h0, 32'h0);
    rd2(4'd5, "R7 ident", 32'h0, 32'h0);
  endtask

  task automatic t_id_vs_write;
    @(negedge clk);
    rst_n = 1'b1;
    wr_en = 1'b1; wr_addr = 4'd5; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_en = 1'b0;
    rd2(4'd5, "R8 ident load wins", ID_MAIN, ID_ALT);
  endtask

  task automatic t_status;
    wr(4'd0, 32'hFFFF_FFFF);
    rd2(4'd0, "R4 R5 R6 status ones", 32'h0080_0007, 32'h00BF_03F9);
    wr(4'd0, 32'h0000_0000);
    rd2(4'd0, "R4 R5 status zeros", 32'h0080_0000, 32'h0000_0000);
    wr(4'd0, 32'h0000_0001);
    rd2(4'd0, "R3 status pie", 32'h0080_0001, 32'h0000_0001);
  endtask

  task automatic t_full_and_ro;
    wr(4'd1, 32'hA5A5_5A5A);
    wr(4'd2, 32'h1357_9BDF);
    wr(4'd12, 32'hCAFE_F00D);
    rd2(4'd1, "R3 R1 esave", 32'hA5A5_5A5A, 32'hA5A5_5A5A);
    rd2(4'd2, "R3 bsave", 32'h1357_9BDF, 32'h1357_9BDF);
    rd2(4'd12, "R3 faultva", 32'hCAFE_F00D, 32'hCAFE_F00D);
    wr(4'd5, 32'h0BAD_0BAD);
    rd2(4'd5, "R3 ident ro", ID_MAIN, ID_ALT);
    wr(4'd7, 32'hFFFF_FFFF);
    rd2(4'd7, "R3 cause ro", 32'h0, 32'h0);
  endtask

  task automatic t_irq_regs;
    wr(4'd3, 32'h1234_5678);
    rd2(4'd3, "R5 R4 irq enable", 32'h1234_5678, 32'h0);
    wr(4'd4, 32'hFFFF_FFFF);
    rd2(4'd4, "R5 R4 irq pending", 32'h0, 32'h0);
  endtask

  task automatic t_mmu;
    wr(4'd8, 32'hFFFF_FFFF);
    rd2(4'd8, "R6 pte", 32'hFFFF_FFFC, 32'h0);
    wr(4'd10, 32'hFFFF_FFFF);
    rd2(4'd10, "R6 tlbctl", 32'h0F3F_FFC0, 32'h0);
    wr(4'd9, 32'h8765_4321);
    rd2(4'd9, "R6 tlbdata", 32'h8765_4321, 32'h0);
  endtask

  task automatic t_absent;
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd11, 32'hFFFF_FFFF);
    wr(4'd13, 32'hFFFF_FFFF);
    wr(4'd14, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    rd2(4'd6, "R2 idx6", 32'h0, 32'h0);
    rd2(4'd11, "R2 idx11", 32'h0, 32'h0);
    rd2(4'd13, "R2 idx13", 32'h0, 32'h0);
    rd2(4'd15, "R2 idx15", 32'h0, 32'h0);
    rd2(4'd1, "R1 esave untouched", 32'hA5A5_5A5A, 32'hA5A5_5A5A);
  endtask

  task automatic t_comb_read;
    @(negedge clk);
    rd2(4'd12, "R9 read a", 32'hCAFE_F00D, 32'hCAFE_F00D);
    rd2(4'd2, "R9 read b", 32'h1357_9BDF, 32'h1357_9BDF);
    rd2(4'd0, "R9 read c", 32'h0080_0001, 32'h0000_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_id_vs_write();
    t_status();
    t_full_and_ro();
    t_irq_regs();
    t_mmu();
    t_absent();
    t_comb_read();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule